// File: doc/BRIEF.md
# Four-bit ALU slice with group carry outputs

This block is a purely combinational arithmetic logic unit slice, four bits wide by default. It takes two operands, a four-bit function code, a mode bit and a carry input. It returns a result word, a carry output for chaining slices by ripple, and a group generate and group propagate pair for an external lookahead unit. It also returns a flag that is high when every result bit is 1.

When the mode bit is high, the block applies one of sixteen bitwise logic functions. In this mode each result bit depends only on the operand bits at the same position. When the mode bit is low, it applies one of sixteen arithmetic functions over the whole word, and the carry input adds exactly one to the result. Internal carries are formed by lookahead expressions from per-bit terms, not by a chain.

The result, flags and carries all settle within the same cycle as the inputs. Wider words are built either by feeding one slice's carry output into the next slice's carry input, or by forming the upper carry input as `grp_gen | (grp_prop & carry_in)` of the lower slice.

Top module: `alu_slice`

## Requirements
- R1: With `logic_mode`=1, `result` bit i depends only on `op_a[i]` and `op_b[i]`. For `fsel` (bit 3 down to bit 0) the functions are:
  - 0000 NOT A; 0001 NOR; 0010 (NOT A) AND B; 0011 constant 0;
  - 0100 NAND; 0101 NOT B; 0110 XOR; 0111 A AND (NOT B);
  - 1000 (NOT A) OR B; 1001 XNOR; 1010 B; 1011 AND;
  - 1100 constant all ones; 1101 A OR (NOT B); 1110 OR; 1111 A.
- R2: With `logic_mode`=0 and `carry_in`=0, `result` is the following, modulo 16:
  - 0000 A; 0001 A|B; 0010 A|~B; 0011 all ones;
  - 0100 A+(A&~B); 0101 (A|B)+(A&~B); 0110 A-B-1; 0111 (A&~B)-1;
  - 1000 A+(A&B); 1001 A+B; 1010 (A|~B)+(A&B); 1011 (A&B)-1;
  - 1100 A+A; 1101 (A|B)+A; 1110 (A|~B)+A; 1111 A-1.
  
  The "minus" forms are computed as additions of all-ones or of ~B.
- R3: In arithmetic mode, `carry_in`=1 adds exactly one to the R2 result. In logic mode, `carry_in` has no effect on `result` or `all_ones`.
- R4: Code 0110 in arithmetic mode gives A-B-1 with `carry_in`=0 and A-B with `carry_in`=1. With `carry_in`=1, `carry_out`=1 means A>=B (no borrow) and `carry_out`=0 means A<B.
- R5: `carry_out` (active high) is the bit above the top bit of the R2 sum plus `carry_in`. It is formed from the same select terms in both modes and never alters `result`.
- R6: `grp_gen` equals the carry out of the R2 sum with no carry in. When `grp_gen` is 0, `grp_prop` is 1 exactly when that sum is all ones. Neither output depends on `carry_in`, and `carry_out` equals `grp_gen | (grp_prop & carry_in)`.
- R7: `all_ones` is 1 exactly when every `result` bit is 1. With code 0110, arithmetic mode and `carry_in`=0, it is 1 exactly when A equals B.
- R8: Two slices, with the lower `carry_out` driving the upper `carry_in`, give the 8-bit form of R1 to R5, including the 8-bit carry out.
- R9: Two slices, with the upper `carry_in` driven by the lower `grp_gen | (grp_prop & carry_in)`, give the same 8-bit results as R8.
- R10: The carry into every bit position equals that bit's lookahead expression. That expression must agree with the per-bit recurrence c[i+1] = r[i] | (l[i] & c[i]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| fsel | input | 4 | Function code, bit 3 down to bit 0 |
| logic_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in | input | 1 | Active-high carry into bit 0 |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Active-high carry out of the top bit |
| grp_prop | output | 1 | Group propagate, independent of carry_in |
| grp_gen | output | 1 | Group generate, independent of carry_in |
| all_ones | output | 1 | High when every result bit is 1 |

## Verification
The block holds no state. A wrong per-bit term or a wrong lookahead carry therefore shows at the ports in the same cycle as the input that exposes it, either on `result`, on `carry_out`, or on the group pair.

A fault in a carry path appears only for operand pairs that actually generate or propagate through that position. For this reason every combination of operands, code, mode and carry is applied to one slice. Faults that appear only across slice boundaries show when two slices are cascaded, both through ripple and through the group outputs, and are compared against an 8-bit model.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int unsigned SEL_W = 4;
  typedef logic [SEL_W-1:0] fsel_t;
  // Codes the embedded checks rely on
  localparam fsel_t SEL_SUB    = 4'b0110;
  localparam fsel_t SEL_PASS_A = 4'b1111;
  localparam fsel_t SEL_ZERO   = 4'b0011;
endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  fsel_t            fsel,
  output logic [WIDTH-1:0] lterm,
  output logic [WIDTH-1:0] rterm
);
  // lterm: left addend bit (also the bit's propagate term)
  // rterm: right addend bit (also the bit's generate term)
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign lterm[i] = op_a[i] | (op_b[i] & fsel[0]) | (~op_b[i] & fsel[1]);
    assign rterm[i] = (op_a[i] & ~op_b[i] & fsel[2]) | (op_a[i] & op_b[i] & fsel[3]);

    // R10: a bit that generates must also propagate, so the lookahead sum is exact
    always_comb begin
      term_nest_chk: assert (!(rterm[i] && !lterm[i]))
        else $error("R10 generate without propagate at bit %0d", i);
    end
  end
endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] lterm,
  input  logic [WIDTH-1:0] rterm,
  input  logic             carry_in,
  output logic [WIDTH:0]   carry,
  output logic             grp_gen,
  output logic             grp_prop
);
  // Each carry is a flat OR of AND products, one product per source bit
  always_comb begin
    logic run;
    logic acc;
    for (int i = 0; i <= WIDTH; i++) begin
      run = 1'b1;
      acc = 1'b0;
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & rterm[j]);
        run = run & lterm[j];
      end
      carry[i] = acc | (run & carry_in);
    end
  end

  // Group terms: the same expansion for the top position, with no carry in
  always_comb begin
    logic run;
    logic acc;
    run = 1'b1;
    acc = 1'b0;
    for (int j = WIDTH - 1; j >= 0; j--) begin
      acc = acc | (run & rterm[j]);
      run = run & lterm[j];
    end
    grp_gen  = acc;
    grp_prop = run;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    // R10: lookahead carry agrees with the per-bit recurrence
    always_comb begin
      carry_ripple_chk: assert (carry[i+1] == (rterm[i] | (lterm[i] & carry[i])))
        else $error("R10 carry mismatch into bit %0d", i + 1);
    end
  end

  // R6: top carry matches the group pair combined with carry in
  always_comb begin
    group_carry_chk: assert (carry[WIDTH] == (grp_gen | (grp_prop & carry_in)))
      else $error("R6 group terms disagree with carry out");
  end
endmodule

// File: rtl/alu_result.sv
module alu_result #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] lterm,
  input  logic [WIDTH-1:0] rterm,
  input  logic [WIDTH-1:0] carry,
  input  logic             logic_mode,
  output logic [WIDTH-1:0] result,
  output logic             all_ones
);
  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] bit_cin;

  // In logic mode every bit sees a forced-high carry term, cutting the chain
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign half_sum[i] = lterm[i] ^ rterm[i];
    assign bit_cin[i]  = logic_mode | carry[i];
    assign result[i]   = half_sum[i] ^ bit_cin[i];
  end

  assign all_ones = &result;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       fsel,
  input  logic             logic_mode,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             grp_prop,
  output logic             grp_gen,
  output logic             all_ones
);
  logic [WIDTH-1:0] lterm;
  logic [WIDTH-1:0] rterm;
  logic [WIDTH:0]   carry;

  alu_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .op_a (op_a),
    .op_b (op_b),
    .fsel (fsel),
    .lterm(lterm),
    .rterm(rterm)
  );

  alu_lookahead #(.WIDTH(WIDTH)) u_cla (
    .lterm   (lterm),
    .rterm   (rterm),
    .carry_in(carry_in),
    .carry   (carry),
    .grp_gen (grp_gen),
    .grp_prop(grp_prop)
  );

  alu_result #(.WIDTH(WIDTH)) u_res (
    .lterm     (lterm),
    .rterm     (rterm),
    .carry     (carry[WIDTH-1:0]),
    .logic_mode(logic_mode),
    .result    (result),
    .all_ones  (all_ones)
  );

  assign carry_out = carry[WIDTH];

  always_comb begin
    // R2
    arith_sum_chk: assert (logic_mode ||
      ({carry_out, result} == ({1'b0, lterm} + {1'b0, rterm} + {{WIDTH{1'b0}}, carry_in})))
      else $error("R2 lookahead sum differs from plain addition");
    // R7
    eq_compare_chk: assert (logic_mode || carry_in || (fsel != SEL_SUB) ||
      (all_ones == (op_a == op_b)))
      else $error("R7 equality flag wrong in subtract mode");
    // R4
    no_borrow_chk: assert (logic_mode || !carry_in || (fsel != SEL_SUB) ||
      (carry_out == (op_a >= op_b)))
      else $error("R4 borrow indication wrong");
    // R1
    logic_pass_chk: assert (!logic_mode || (fsel != SEL_PASS_A) || (result == op_a))
      else $error("R1 pass-through of A wrong");
    // R1
    logic_zero_chk: assert (!logic_mode || (fsel != SEL_ZERO) || (result == '0))
      else $error("R1 constant zero wrong");
  end
endmodule

// File: tb/sim_alu_slice.sv
`timescale 1ns/1ps
module sim_alu_slice;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Single slice under exhaustive sweep
  logic [3:0] a, b, s, f;
  logic m, ci, co, gp, gg, eq;

  alu_slice #(.WIDTH(4)) u0 (
    .op_a(a), .op_b(b), .fsel(s), .logic_mode(m), .carry_in(ci),
    .result(f), .carry_out(co), .grp_prop(gp), .grp_gen(gg), .all_ones(eq)
  );

  // Cascaded pairs
  logic [7:0] ca, cb;
  logic [3:0] cs;
  logic cm, cci;
  logic [3:0] rf_lo, rf_hi, lf_lo, lf_hi;
  logic r_mid, r_co, l_mid, l_co, lp_lo, lg_lo;
  logic rp_lo, rg_lo, rp_hi, rg_hi, re_lo, re_hi, lp_hi, lg_hi, le_lo, le_hi;

  alu_slice #(.WIDTH(4)) u_rlo (
    .op_a(ca[3:0]), .op_b(cb[3:0]), .fsel(cs), .logic_mode(cm), .carry_in(cci),
    .result(rf_lo), .carry_out(r_mid), .grp_prop(rp_lo), .grp_gen(rg_lo), .all_ones(re_lo)
  );
  alu_slice #(.WIDTH(4)) u_rhi (
    .op_a(ca[7:4]), .op_b(cb[7:4]), .fsel(cs), .logic_mode(cm), .carry_in(r_mid),
    .result(rf_hi), .carry_out(r_co), .grp_prop(rp_hi), .grp_gen(rg_hi), .all_ones(re_hi)
  );

  logic l_hcin;
  assign l_hcin = lg_lo | (lp_lo & cci);

  alu_slice #(.WIDTH(4)) u_llo (
    .op_a(ca[3:0]), .op_b(cb[3:0]), .fsel(cs), .logic_mode(cm), .carry_in(cci),
    .result(lf_lo), .carry_out(l_mid), .grp_prop(lp_lo), .grp_gen(lg_lo), .all_ones(le_lo)
  );
  alu_slice #(.WIDTH(4)) u_lhi (
    .op_a(ca[7:4]), .op_b(cb[7:4]), .fsel(cs), .logic_mode(cm), .carry_in(l_hcin),
    .result(lf_hi), .carry_out(l_co), .grp_prop(lp_hi), .grp_gen(lg_hi), .all_ones(le_hi)
  );

  // Reference: arithmetic table as integer sums, carry at bit w
  function automatic logic [8:0] ref_arith(input logic [7:0] ra, input logic [7:0] rb,
                                           input logic [3:0] rs, input logic rc, input int w);
    logic [8:0] msk, x, y, nb, r;
    msk = (9'd1 << w) - 9'd1;
    x  = {1'b0, ra} & msk;
    y  = {1'b0, rb} & msk;
    nb = ~y & msk;
    case (rs)
      4'h0: r = x;
      4'h1: r = x | y;
      4'h2: r = x | nb;
      4'h3: r = msk;
      4'h4: r = x + (x & nb);
      4'h5: r = (x | y) + (x & nb);
      4'h6: r = x + nb;
      4'h7: r = (x & nb) + msk;
      4'h8: r = x + (x & y);
      4'h9: r = x + y;
      4'hA: r = (x | nb) + (x & y);
      4'hB: r = (x & y) + msk;
      4'hC: r = x + x;
      4'hD: r = (x | y) + x;
      4'hE: r = (x | nb) + x;
      default: r = x + msk;
    endcase
    return r + {8'd0, rc};
  endfunction

  function automatic logic [7:0] ref_logic(input logic [7:0] x, input logic [7:0] y,
                                           input logic [3:0] rs);
    case (rs)
      4'h0: return ~x;
      4'h1: return ~(x | y);
      4'h2: return ~x & y;
      4'h3: return 8'h00;
      4'h4: return ~(x & y);
      4'h5: return ~y;
      4'h6: return x ^ y;
      4'h7: return x & ~y;
      4'h8: return ~x | y;
      4'h9: return ~(x ^ y);
      4'hA: return y;
      4'hB: return x & y;
      4'hC: return 8'hFF;
      4'hD: return x | ~y;
      4'hE: return x | y;
      default: return x;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%h b=%h s=%h m=%0d ci=%0d actual=%h expected=%h",
               req, a, b, s, m, ci, act, exp);
    end
  endtask

  task automatic check_single();
    logic [8:0] s_c, s_0;
    logic [3:0] ef;
    s_c = ref_arith({4'd0, a}, {4'd0, b}, s, ci, 4);
    s_0 = ref_arith({4'd0, a}, {4'd0, b}, s, 1'b0, 4);
    if (m) begin
      ef = ref_logic({4'd0, a}, {4'd0, b}, s)[3:0];
      // R1 table; R3 carry_in ignored in logic mode (cin both values land here)
      chk(f == ef, ci ? "R3 logic ignores cin" : "R1 logic table", {12'd0, f}, {12'd0, ef});
    end else begin
      ef = s_c[3:0];
      chk(f == ef, ci ? "R3 carry adds one" : "R2 arith table", {12'd0, f}, {12'd0, ef});
      if (s == 4'b0110) begin
        chk(f == (ci ? a - b : a - b - 4'd1), "R4 subtract value", {12'd0, f},
            {12'd0, ci ? a - b : a - b - 4'd1});
        if (ci) chk(co == (a >= b), "R4 borrow flag", {15'd0, co}, {15'd0, a >= b});
        else    chk(eq == (a == b), "R7 equality in subtract", {15'd0, eq}, {15'd0, a == b});
      end
    end
    chk(co == s_c[4], "R5 carry out", {15'd0, co}, {15'd0, s_c[4]});
    chk(gg == s_0[4], "R6 group generate", {15'd0, gg}, {15'd0, s_0[4]});
    if (!s_0[4])
      chk(gp == (s_0[3:0] == 4'hF), "R6 group propagate", {15'd0, gp}, {15'd0, s_0[3:0] == 4'hF});
    chk(eq == (f == 4'hF), "R7 all ones flag", {15'd0, eq}, {15'd0, f == 4'hF});
  endtask

  task automatic check_cascade();
    logic [8:0] e9;
    logic [7:0] ef;
    e9 = ref_arith(ca, cb, cs, cci, 8);
    ef = cm ? ref_logic(ca, cb, cs) : e9[7:0];
    checks++;
    if ({rf_hi, rf_lo} != ef || r_co != e9[8]) begin
      fails++;
      $display("FAIL R8 ripple cascade a=%h b=%h s=%h m=%0d ci=%0d actual=%h expected=%h",
               ca, cb, cs, cm, cci, {r_co, rf_hi, rf_lo}, {e9[8], ef});
    end
    checks++;
    if ({lf_hi, lf_lo} != ef || l_co != e9[8]) begin
      fails++;
      $display("FAIL R9 lookahead cascade a=%h b=%h s=%h m=%0d ci=%0d actual=%h expected=%h",
               ca, cb, cs, cm, cci, {l_co, lf_hi, lf_lo}, {e9[8], ef});
    end
  endtask

  task automatic drive_single(input logic [13:0] v);
    @(posedge clk);
    {m, ci, s, b, a} = v;
    @(negedge clk);
    check_single();
  endtask

  task automatic drive_cascade(input logic [7:0] xa, input logic [7:0] xb,
                               input logic [3:0] xs, input logic xm, input logic xc);
    @(posedge clk);
    ca = xa; cb = xb; cs = xs; cm = xm; cci = xc;
    @(negedge clk);
    check_cascade();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    a = '0; b = '0; s = '0; m = 1'b0; ci = 1'b0;
    ca = '0; cb = '0; cs = '0; cm = 1'b0; cci = 1'b0;
    seed = $urandom(32'h0000_5EED);
    @(negedge clk);
    // Quiescent inputs: A+... code 0000 arithmetic gives A = 0, flags low
    chk(f == 4'h0 && co == 1'b0 && eq == 1'b0, "R2 idle inputs", {11'd0, co, eq, f}, 16'h0000);

    // Directed corners: subtract with equal, greater and smaller operands
    drive_single({1'b0, 1'b0, 4'b0110, 4'h9, 4'h9}); // R7 A==B gives all ones
    chk(eq == 1'b1, "R7 directed equal", {15'd0, eq}, 16'd1);
    drive_single({1'b0, 1'b1, 4'b0110, 4'h3, 4'h2}); // R4 2-3 borrows
    chk(co == 1'b0 && f == 4'hF, "R4 directed borrow", {11'd0, co, 1'b0, f}, 16'h000F);
    drive_single({1'b0, 1'b1, 4'b1001, 4'hF, 4'h1}); // R3 1+15+1
    chk(co == 1'b1 && f == 4'h1, "R3 directed carry wrap", {11'd0, co, 1'b0, f}, 16'h0021);

    // Exhaustive sweep of one slice
    for (int v = 0; v < 16384; v++) drive_single(v[13:0]);

    // Cascade corners: full carry run across the slice boundary
    drive_cascade(8'hFF, 8'h00, 4'b1001, 1'b0, 1'b1);
    drive_cascade(8'h0F, 8'h01, 4'b1001, 1'b0, 1'b0);
    drive_cascade(8'h80, 8'h81, 4'b0110, 1'b0, 1'b1);
    drive_cascade(8'h5A, 8'h5A, 4'b0110, 1'b0, 1'b0);
    drive_cascade(8'hC3, 8'h3C, 4'b0110, 1'b1, 1'b1);

    // Random cascades
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] rv;
      rv = $urandom();
      drive_cascade(rv[7:0], rv[15:8], rv[19:16], rv[20], rv[21]);
    end

    finish_run();
  end
endmodule